// File: doc/BRIEF.md
# Operand-Priority Bus Controller

This block owns a single internal bus and shares it between two clients: a microsequencer that issues operand reads and writes, and an instruction prefetcher that asks for instruction words. Operand traffic always wins. A prefetch only starts when no operand access is pending. This keeps bus time for the data the running instruction needs, rather than for instruction words that a change of flow may later discard.

The microsequencer sees a single holding slot. It serves three purposes at once: it is the queue for a request that arrives while another bus cycle is running, it is the write-pending buffer that lets execution carry on once a write is handed over, and it is the interlock. While the slot is occupied the ready output is low, and a new request waits. Byte and word operands take one bus cycle each. A 32-bit (long) operand takes two back-to-back word cycles, the high half first. Read results come back with a one-cycle done pulse, and the two halves of a long read are joined before that pulse.

Every bus cycle uses a request/ready handshake. The controller raises `bus_req` with a stable address, direction and write data. The cycle ends on the clock edge where `bus_rdy` is sampled high.

Top module: `opbus_ctrl`

## Requirements
- R1: When an operand request and a prefetch request compete for the same free bus slot, the operand cycle is started and the prefetch waits until no operand access is pending.
- R2: An operand request that arrives while a bus cycle is running is accepted into the slot if it is empty, and its first bus cycle starts in the clock cycle right after the running cycle completes.
- R3: `op_size` encodes 0 = byte, 1 = word and 2 = long. A byte or word operand uses exactly one bus cycle. For a byte access `bus_byte` is high and a write places `op_wdata[7:0]` on every byte lane of `bus_wdata`. A byte read returns `bus_rdata[7:0]` zero-extended. A word read returns `bus_rdata` zero-extended.
- R4: A long operand uses two consecutive bus cycles with no other cycle between them. The first goes to `op_addr` and carries or returns bits 31:16. The second goes to `op_addr + 2` and carries or returns bits 15:0.
- R5: A read raises `op_done` for exactly one clock, in the cycle after its last bus cycle completes, with the full result on `op_rdata`.
- R6: A write is complete for the requester once it is accepted, and no `op_done` is raised for it. The slot is freed, and `op_rdy` is high, in the same cycle that its last bus cycle completes.
- R7: While the slot holds an unfinished access, `op_rdy` is low and a presented request is neither accepted nor allowed to disturb the held access. The presented request is taken once the slot frees.
- R8: Once `bus_req` is high, the address, direction, byte flag and write data stay unchanged until `bus_rdy` is sampled high.
- R9: `pf_gnt` pulses in the cycle a prefetch is selected, and `pf_addr` is captured then. `pf_done` marks the completing cycle of that prefetch, with the fetched word on `pf_rdata`.
- R10: After reset `bus_req` and `op_done` are low and `op_rdy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_req | input | 1 | Operand request valid |
| op_we | input | 1 | Operand request is a write |
| op_size | input | 2 | Operand size: 0 byte, 1 word, 2 long |
| op_addr | input | ADDR_W | Operand byte address |
| op_wdata | input | 2*BUS_W | Operand write data, right-aligned |
| op_rdy | output | 1 | Slot can take a request this cycle |
| op_done | output | 1 | One-cycle pulse: read result valid |
| op_rdata | output | 2*BUS_W | Read result, right-aligned |
| pf_req | input | 1 | Prefetch request valid |
| pf_addr | input | ADDR_W | Prefetch word address |
| pf_gnt | output | 1 | Prefetch selected; address taken |
| pf_done | output | 1 | Prefetch bus cycle completes |
| pf_rdata | output | BUS_W | Fetched instruction word |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | Bus cycle is a write |
| bus_byte | output | 1 | Bus cycle moves a single byte |
| bus_addr | output | ADDR_W | Bus cycle address |
| bus_wdata | output | BUS_W | Bus write data |
| bus_rdy | input | 1 | Bus cycle completes on this edge |
| bus_rdata | input | BUS_W | Bus read data, valid with `bus_rdy` |

## Verification
The assertions assume that requesters obey the handshake. A microsequencer request stays steady until it is taken while `op_rdy` is high. `pf_req` and `pf_addr` do not change in the same cycle as `pf_gnt` until the grant has been observed. The bus responder only drives `bus_rdy` while `bus_req` is high. The directed bench keeps to these rules. Inputs change only on the falling edge. An operand request is lowered on the edge after it is accepted. The model prefetcher moves its address only after a grant. The model memory answers a fixed number of cycles after it sees `bus_req`, and returns a data word computed from the address.

// File: rtl/opbus_pkg.sv
package opbus_pkg;

    // Operand size encoding shared by all submodules and the bench.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

endpackage

// File: rtl/opbus_slot.sv
// Single holding register: request queue, write-pending buffer and interlock.
module opbus_slot
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int OP_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              clear,
    input  logic              in_we,
    input  opsize_e           in_size,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [OP_W-1:0]   in_data,
    output logic              vld,
    output logic              we,
    output opsize_e           size,
    output logic [ADDR_W-1:0] addr,
    output logic [OP_W-1:0]   data
);

    typedef struct packed {
        logic              vld;
        logic              we;
        opsize_e           size;
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (load) begin
            // A new request may enter on the very cycle the old one retires.
            slot_d.vld  = 1'b1;
            slot_d.we   = in_we;
            slot_d.size = in_size;
            slot_d.addr = in_addr;
            slot_d.data = in_data;
        end else if (clear) begin
            slot_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_d;
        end
    end

    assign vld  = slot_q.vld;
    assign we   = slot_q.we;
    assign size = slot_q.size;
    assign addr = slot_q.addr;
    assign data = slot_q.data;

endmodule

// File: rtl/opbus_seq.sv
// Bus cycle sequencer: owner selection, long-operand phase, prefetch capture.
module opbus_seq #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_pending,
    input  logic              op_long,
    input  logic              bus_rdy,
    input  logic              pf_req,
    input  logic [ADDR_W-1:0] pf_addr,
    output logic              busy,
    output logic              own_op,
    output logic              phase,
    output logic              op_half,
    output logic              op_last,
    output logic              pf_gnt,
    output logic              pf_done,
    output logic [ADDR_W-1:0] pf_addr_q
);

    typedef struct packed {
        logic              busy;
        logic              own_op;
        logic              phase;
        logic [ADDR_W-1:0] pf_addr;
    } seq_t;

    seq_t seq_d, seq_q;
    logic finish;
    logic free;

    always_comb begin
        finish  = seq_q.busy & bus_rdy;
        op_half = finish & seq_q.own_op & op_long & ~seq_q.phase;
        op_last = finish & seq_q.own_op & ~(op_long & ~seq_q.phase);
        pf_done = finish & ~seq_q.own_op;
        free    = ~seq_q.busy | op_last | pf_done;
        pf_gnt  = free & ~op_pending & pf_req;

        seq_d = seq_q;
        if (op_half) begin
            // Second half follows at once; nothing may cut in.
            seq_d.phase = 1'b1;
        end else if (free) begin
            seq_d.phase = 1'b0;
            if (op_pending) begin
                seq_d.busy   = 1'b1;
                seq_d.own_op = 1'b1;
            end else if (pf_req) begin
                seq_d.busy    = 1'b1;
                seq_d.own_op  = 1'b0;
                seq_d.pf_addr = pf_addr;
            end else begin
                seq_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy      = seq_q.busy;
    assign own_op    = seq_q.own_op;
    assign phase     = seq_q.phase;
    assign pf_addr_q = seq_q.pf_addr;

endmodule

// File: rtl/opbus_lane.sv
// Bus-side formatting of address and write data, read result assembly.
module opbus_lane
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                busy,
    input  logic                own_op,
    input  logic                phase,
    input  logic                op_half,
    input  logic                op_last,
    input  logic                s_we,
    input  opsize_e             s_size,
    input  logic [ADDR_W-1:0]   s_addr,
    input  logic [2*BUS_W-1:0]  s_data,
    input  logic [ADDR_W-1:0]   pf_addr_q,
    input  logic [BUS_W-1:0]    bus_rdata,
    output logic                bus_we,
    output logic                bus_byte,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [BUS_W-1:0]    bus_wdata,
    output logic                op_done,
    output logic [2*BUS_W-1:0]  op_rdata
);

    localparam int OP_W  = 2 * BUS_W;
    localparam int LANES = BUS_W / 8;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(LANES);

    typedef struct packed {
        logic [BUS_W-1:0] hi;
        logic             done;
        logic [OP_W-1:0]  rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        bus_we   = busy & own_op & s_we;
        bus_byte = busy & own_op & (s_size == SZ_BYTE);
        bus_addr = own_op ? (s_addr + (phase ? STEP : '0)) : pf_addr_q;

        bus_wdata = '0;
        if (own_op) begin
            unique case (s_size)
                SZ_BYTE: bus_wdata = {LANES{s_data[7:0]}};
                SZ_LONG: bus_wdata = phase ? s_data[BUS_W-1:0] : s_data[OP_W-1:BUS_W];
                default: bus_wdata = s_data[BUS_W-1:0];
            endcase
        end
    end

    always_comb begin
        rd_d      = rd_q;
        rd_d.done = op_last & ~s_we;
        if (op_half && !s_we) begin
            rd_d.hi = bus_rdata;
        end
        if (op_last && !s_we) begin
            unique case (s_size)
                SZ_BYTE: rd_d.rdata = {{(OP_W-8){1'b0}}, bus_rdata[7:0]};
                SZ_LONG: rd_d.rdata = {rd_q.hi, bus_rdata};
                default: rd_d.rdata = {{(OP_W-BUS_W){1'b0}}, bus_rdata};
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign op_done  = rd_q.done;
    assign op_rdata = rd_q.rdata;

endmodule

// File: rtl/opbus_ctrl.sv
// Top: operand-priority bus controller with a single holding slot.
module opbus_ctrl
    import opbus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                op_req,
    input  logic                op_we,
    input  logic [1:0]          op_size,
    input  logic [ADDR_W-1:0]   op_addr,
    input  logic [2*BUS_W-1:0]  op_wdata,
    output logic                op_rdy,
    output logic                op_done,
    output logic [2*BUS_W-1:0]  op_rdata,
    input  logic                pf_req,
    input  logic [ADDR_W-1:0]   pf_addr,
    output logic                pf_gnt,
    output logic                pf_done,
    output logic [BUS_W-1:0]    pf_rdata,
    output logic                bus_req,
    output logic                bus_we,
    output logic                bus_byte,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [BUS_W-1:0]    bus_wdata,
    input  logic                bus_rdy,
    input  logic [BUS_W-1:0]    bus_rdata
);

    localparam int OP_W = 2 * BUS_W;

    logic              slot_vld;
    logic              slot_we;
    opsize_e           slot_size;
    logic [ADDR_W-1:0] slot_addr;
    logic [OP_W-1:0]   slot_data;
    logic              busy;
    logic              own_op;
    logic              phase;
    logic              op_half;
    logic              op_last;
    logic [ADDR_W-1:0] pf_addr_q;
    logic              accept;
    logic              op_pending;

    // The slot frees on the completing edge of its last bus cycle.
    assign op_rdy     = ~slot_vld | op_last;
    assign accept     = op_req & op_rdy;
    assign op_pending = accept | (slot_vld & ~op_last);
    assign bus_req    = busy;
    assign pf_rdata   = bus_rdata;

    opbus_slot #(
        .ADDR_W (ADDR_W),
        .OP_W   (OP_W)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .clear   (op_last),
        .in_we   (op_we),
        .in_size (opsize_e'(op_size)),
        .in_addr (op_addr),
        .in_data (op_wdata),
        .vld     (slot_vld),
        .we      (slot_we),
        .size    (slot_size),
        .addr    (slot_addr),
        .data    (slot_data)
    );

    opbus_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_pending (op_pending),
        .op_long    (slot_size == SZ_LONG),
        .bus_rdy    (bus_rdy),
        .pf_req     (pf_req),
        .pf_addr    (pf_addr),
        .busy       (busy),
        .own_op     (own_op),
        .phase      (phase),
        .op_half    (op_half),
        .op_last    (op_last),
        .pf_gnt     (pf_gnt),
        .pf_done    (pf_done),
        .pf_addr_q  (pf_addr_q)
    );

    opbus_lane #(
        .ADDR_W (ADDR_W),
        .BUS_W  (BUS_W)
    ) u_lane (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (busy),
        .own_op    (own_op),
        .phase     (phase),
        .op_half   (op_half),
        .op_last   (op_last),
        .s_we      (slot_we),
        .s_size    (slot_size),
        .s_addr    (slot_addr),
        .s_data    (slot_data),
        .pf_addr_q (pf_addr_q),
        .bus_rdata (bus_rdata),
        .bus_we    (bus_we),
        .bus_byte  (bus_byte),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .op_done   (op_done),
        .op_rdata  (op_rdata)
    );

endmodule

// File: rtl/opbus_ctrl_chk.sv
module opbus_ctrl_chk #(
    parameter int ADDR_W = 24,
    parameter int BUS_W  = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                op_req,
    input logic                op_rdy,
    input logic                op_done,
    input logic                pf_gnt,
    input logic                pf_done,
    input logic                bus_req,
    input logic                bus_rdy,
    input logic                bus_we,
    input logic                bus_byte,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [BUS_W-1:0]    bus_wdata,
    input logic                slot_vld,
    input logic [ADDR_W-1:0]   slot_addr,
    input logic [2*BUS_W-1:0]  slot_data,
    input logic                op_half,
    input logic                op_last
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(BUS_W / 8);

    // R1
    op_beats_pf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_gnt |-> !(op_req && op_rdy));

    // R2
    queued_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_done && slot_vld) |=> (bus_req && bus_addr == $past(slot_addr)));

    // R4
    long_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_half |=> (bus_req && bus_addr == $past(bus_addr) + STEP && bus_we == $past(bus_we)));

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R6
    write_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_last && bus_we) |-> op_rdy);

    // R7
    slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_rdy |=> (slot_vld && $stable(slot_addr) && $stable(slot_data)));

    // R8
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_rdy) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                   && $stable(bus_byte) && $stable(bus_wdata)));

    // R9
    pf_done_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pf_done |-> (bus_req && bus_rdy && !bus_we));

endmodule

bind opbus_ctrl opbus_ctrl_chk #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_req    (op_req),
    .op_rdy    (op_rdy),
    .op_done   (op_done),
    .pf_gnt    (pf_gnt),
    .pf_done   (pf_done),
    .bus_req   (bus_req),
    .bus_rdy   (bus_rdy),
    .bus_we    (bus_we),
    .bus_byte  (bus_byte),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .slot_vld  (slot_vld),
    .slot_addr (slot_addr),
    .slot_data (slot_data),
    .op_half   (op_half),
    .op_last   (op_last)
);

// File: tb/opbus_ctrl_tb.sv
`timescale 1ns/1ps
module opbus_ctrl_tb;

    localparam int AW = 24;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          op_req = 1'b0;
    logic          op_we = 1'b0;
    logic [1:0]    op_size = 2'd0;
    logic [AW-1:0] op_addr = '0;
    logic [31:0]   op_wdata = '0;
    logic          op_rdy;
    logic          op_done;
    logic [31:0]   op_rdata;
    logic          pf_req;
    logic [AW-1:0] pf_addr = '0;
    logic          pf_gnt;
    logic          pf_done;
    logic [BW-1:0] pf_rdata;
    logic          bus_req;
    logic          bus_we;
    logic          bus_byte;
    logic [AW-1:0] bus_addr;
    logic [BW-1:0] bus_wdata;
    logic          bus_rdy = 1'b0;
    logic [BW-1:0] bus_rdata = '0;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int wait_cyc = 0;
    int rcnt = 0;
    int pf_left = 0;
    bit gnt_flag = 0;
    int pf_gnt_cnt = 0;
    int done_cnt = 0;
    int pfd_cnt = 0;
    int wr_rdy_bad = 0;
    logic [31:0] last_rdata = '0;
    logic [BW-1:0] last_pf = '0;
    bit inflight = 0;
    int cur_start = 0;
    int n_log = 0;
    logic [AW-1:0] lg_addr  [32];
    logic          lg_we    [32];
    logic          lg_byte  [32];
    logic [BW-1:0] lg_wdata [32];
    int            lg_start [32];
    int            lg_done  [32];

    assign pf_req = (pf_left > 0);

    always #10 clk = ~clk;

    opbus_ctrl #(.ADDR_W(AW), .BUS_W(BW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .op_req(op_req), .op_we(op_we), .op_size(op_size), .op_addr(op_addr),
        .op_wdata(op_wdata), .op_rdy(op_rdy), .op_done(op_done), .op_rdata(op_rdata),
        .pf_req(pf_req), .pf_addr(pf_addr), .pf_gnt(pf_gnt), .pf_done(pf_done),
        .pf_rdata(pf_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_byte(bus_byte), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdy(bus_rdy), .bus_rdata(bus_rdata)
    );

    function automatic logic [BW-1:0] fdat(input logic [AW-1:0] a);
        return a[15:0] ^ 16'hC3A5;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: answers wait_cyc cycles after seeing a request.
    always @(negedge clk) begin
        if (bus_req) begin
            bus_rdata = fdat(bus_addr);
            if (rcnt >= wait_cyc) begin
                bus_rdy = 1'b1;
                rcnt = 0;
            end else begin
                bus_rdy = 1'b0;
                rcnt = rcnt + 1;
            end
        end else begin
            bus_rdy = 1'b0;
            rcnt = 0;
        end
    end

    // Model prefetcher: advances its address after each grant.
    always @(negedge clk) begin
        if (gnt_flag) begin
            gnt_flag = 0;
            pf_addr = pf_addr + 2;
            if (pf_left > 0) pf_left = pf_left - 1;
        end
    end

    // Monitor samples just before each rising edge.
    always @(negedge clk) begin
        #9;
        if (rst_n) begin
            if (pf_gnt) begin gnt_flag = 1; pf_gnt_cnt++; end
            if (op_done) begin done_cnt++; last_rdata = op_rdata; end
            if (pf_done) begin pfd_cnt++; last_pf = pf_rdata; end
            if (bus_req && !inflight) begin inflight = 1; cur_start = cyc; end
            if (bus_req && bus_rdy) begin
                if (n_log < 32) begin
                    lg_addr[n_log]  = bus_addr;
                    lg_we[n_log]    = bus_we;
                    lg_byte[n_log]  = bus_byte;
                    lg_wdata[n_log] = bus_wdata;
                    lg_start[n_log] = cur_start;
                    lg_done[n_log]  = cyc;
                    n_log++;
                end
                inflight = 0;
                if (bus_we && !op_rdy) wr_rdy_bad++;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp_v);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
        end
    endtask

    // Must be called at a falling edge; returns at the falling edge after acceptance.
    task automatic op_issue(input bit we, input logic [1:0] sz, input logic [AW-1:0] a,
                            input logic [31:0] d, output int stalls);
        op_req = 1'b1; op_we = we; op_size = sz; op_addr = a; op_wdata = d;
        stalls = 0;
        forever begin
            #9;
            if (op_rdy) break;
            stalls++;
            @(negedge clk);
        end
        @(negedge clk);
        op_req = 1'b0;
    endtask

    task automatic wait_idle();
        int quiet = 0;
        while (quiet < 3) begin
            @(negedge clk);
            #9;
            if (!bus_req && op_rdy && pf_left == 0) quiet++;
            else quiet = 0;
        end
    endtask

    task automatic t_reset();
        #9;
        chk(bus_req == 1'b0, "R10 bus_req in reset", bus_req, 0);
        @(negedge clk); rst_n = 1'b1;
        #9;
        chk(bus_req == 1'b0, "R10 bus_req idle", bus_req, 0);
        chk(op_rdy == 1'b1, "R10 op_rdy", op_rdy, 1);
        chk(op_done == 1'b0, "R10 op_done", op_done, 0);
    endtask

    task automatic t_word_read();
        int st; int d0;
        wait_cyc = 1; d0 = done_cnt;
        @(negedge clk); n_log = 0;
        op_issue(1'b0, 2'd1, 24'h000100, 32'h0, st);
        wait_idle();
        chk(n_log == 1, "R3 word read cycles", n_log, 1);
        chk(lg_addr[0] == 24'h000100 && !lg_we[0] && !lg_byte[0], "R3 word read attrs", lg_addr[0], 24'h100);
        chk(lg_done[0] - lg_start[0] == 1, "R8 held until ready", lg_done[0] - lg_start[0], 1);
        chk(done_cnt - d0 == 1, "R5 one done pulse", done_cnt - d0, 1);
        chk(last_rdata == {16'h0, fdat(24'h000100)}, "R5 word read data", last_rdata, {16'h0, fdat(24'h000100)});
    endtask

    task automatic t_byte();
        int st; int d0;
        wait_cyc = 0; d0 = done_cnt; wr_rdy_bad = 0;
        @(negedge clk); n_log = 0;
        op_issue(1'b1, 2'd0, 24'h000105, 32'h1122_33A7, st);
        wait_idle();
        chk(n_log == 1 && lg_byte[0] && lg_we[0], "R3 byte write one cycle", n_log, 1);
        chk(lg_wdata[0] == 16'hA7A7, "R3 byte lanes", lg_wdata[0], 16'hA7A7);
        chk(wr_rdy_bad == 0, "R6 rdy at write completion", wr_rdy_bad, 0);
        chk(done_cnt == d0, "R6 no done for write", done_cnt - d0, 0);
        @(negedge clk); n_log = 0;
        op_issue(1'b0, 2'd0, 24'h000107, 32'h0, st);
        wait_idle();
        chk(last_rdata == {24'h0, fdat(24'h000107) & 16'h00FF}, "R3 byte read", last_rdata,
            {24'h0, fdat(24'h000107) & 16'h00FF});
    endtask

    task automatic t_long();
        int st; int k;
        wait_cyc = 1;
        @(negedge clk); n_log = 0;
        op_issue(1'b1, 2'd2, 24'h000200, 32'h1234_5678, st);
        wait_idle();
        chk(n_log == 2, "R4 long write two cycles", n_log, 2);
        chk(lg_addr[0] == 24'h000200 && lg_wdata[0] == 16'h1234, "R4 high half first", lg_wdata[0], 16'h1234);
        chk(lg_addr[1] == 24'h000202 && lg_wdata[1] == 16'h5678, "R4 low half at +2", lg_wdata[1], 16'h5678);
        chk(lg_start[1] == lg_done[0] + 1, "R4 halves adjacent", lg_start[1], lg_done[0] + 1);
        // Long read with prefetches competing.
        @(negedge clk); n_log = 0; pf_addr = 24'h008000; pf_left = 6;
        @(negedge clk);
        op_issue(1'b0, 2'd2, 24'h000300, 32'h0, st);
        wait_idle();
        k = -1;
        for (int i = 0; i < n_log; i++) if (k < 0 && lg_addr[i] == 24'h000300) k = i;
        chk(k >= 0 && k + 1 < n_log && lg_addr[k+1] == 24'h000302, "R4 no prefetch between halves",
            (k >= 0 && k + 1 < n_log) ? lg_addr[k+1] : 0, 24'h302);
        chk(k >= 0 && k + 1 < n_log && lg_start[k+1] == lg_done[k] + 1, "R4 long read adjacent", k, 0);
        chk(last_rdata == {fdat(24'h000300), fdat(24'h000302)}, "R5 long read joined", last_rdata,
            {fdat(24'h000300), fdat(24'h000302)});
    endtask

    task automatic t_priority();
        int st; int p0;
        wait_cyc = 0; p0 = pfd_cnt;
        @(negedge clk); n_log = 0; pf_addr = 24'h009000; pf_left = 1;
        op_issue(1'b0, 2'd1, 24'h000400, 32'h0, st);
        wait_idle();
        chk(n_log == 2 && lg_addr[0] == 24'h000400, "R1 operand first", lg_addr[0], 24'h400);
        chk(lg_addr[1] == 24'h009000, "R1 prefetch after", lg_addr[1], 24'h9000);
        chk(pfd_cnt - p0 == 1 && last_pf == fdat(24'h009000), "R9 prefetch data", last_pf, fdat(24'h009000));
    endtask

    task automatic t_queue();
        int st; int g0;
        wait_cyc = 3; g0 = pf_gnt_cnt;
        @(negedge clk); n_log = 0; pf_addr = 24'h00A000; pf_left = 1;
        while (pf_gnt_cnt == g0) @(negedge clk);
        chk(bus_req == 1'b1, "R9 prefetch cycle running", bus_req, 1);
        op_issue(1'b1, 2'd1, 24'h000500, 32'h0000_BEEF, st);
        chk(st == 0, "R2 accepted while bus busy", st, 0);
        wait_idle();
        chk(n_log == 2 && lg_addr[0] == 24'h00A000 && lg_addr[1] == 24'h000500, "R2 order", lg_addr[1], 24'h500);
        chk(lg_start[1] == lg_done[0] + 1, "R2 starts right after", lg_start[1], lg_done[0] + 1);
        chk(lg_wdata[1] == 16'hBEEF, "R2 queued write data", lg_wdata[1], 16'hBEEF);
    endtask

    task automatic t_interlock();
        int st;
        wait_cyc = 2;
        @(negedge clk); n_log = 0;
        op_issue(1'b1, 2'd2, 24'h000600, 32'hCAFE_F00D, st);
        op_issue(1'b1, 2'd1, 24'h000700, 32'h0000_1357, st);
        chk(st == 5, "R7 stall cycles", st, 5);
        wait_idle();
        chk(n_log == 3 && lg_wdata[0] == 16'hCAFE && lg_wdata[1] == 16'hF00D, "R7 held write intact",
            lg_wdata[1], 16'hF00D);
        chk(lg_addr[2] == 24'h000700 && lg_wdata[2] == 16'h1357, "R7 waiting write taken", lg_wdata[2], 16'h1357);
        chk(lg_start[2] == lg_done[1] + 1, "R6 slot freed at completion", lg_start[2], lg_done[1] + 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_word_read();
        t_byte();
        t_long();
        t_priority();
        t_queue();
        t_interlock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule